// File: doc/BRIEF.md
# Register-Mapped I2C Bus Master

This block is a byte-at-a-time I2C bus master that software drives through a handful of 8-bit registers. The control register enables the engine, raises or drops bus ownership (which produces START and STOP), requests a repeated START, chooses between sending and receiving, and chooses the acknowledge level returned after a received byte. Byte transfers are not started by a command bit. Writing the data register sends a byte, and reading it in receive mode hands over the last received byte and starts the next reception.

Status reports completion of the last byte or bus condition, the acknowledge level the target returned, and whether the ninth clock is in progress. Status also holds a lock flag that works as a hardware semaphore: the read that finds it clear acquires it, and writing one releases it. While the engine is disabled, software can drive the two lines by hand through a direct-control register and read their levels back, which lets it clock a stuck target free. A capability register advertises that feature. Bit timing is derived from the system clock by a divider. Both lines are open-drain: each output only pulls its line low or releases it.

Top module: `i2c_regctl_master`

## Requirements
- R1: After reset, control (offset 0x4) reads 0x00, status (offset 0x8) reads 0x00, direct-control (offset 0x5) reads 0x03, and neither line is pulled low.
- R2: Offset 0x2 reads 0x02, where bit1 set means direct line control is available. Any offset not listed in this section reads 0x00.
- R3: Status bit0 is a lock. A status read that finds it 0 returns 0 and sets it, and later reads return 1. A status write with bit0 = 1 clears it. A status write with bit0 = 0 leaves it unchanged.
- R4: Control bits are bit0 enable, bit1 master, bit2 repeated start, bit3 transmit and bit4 NACK. With enable already 1, a write that takes master from 0 to 1 with transmit set produces a START and then sends the data register byte. When the ninth clock ends, status bit3 (complete) sets and status bit2 holds the SDA level sampled at the ninth SCL rise (0 = ACK).
- R5: A write to data (offset 0xC) while enable and master are 1 sends that byte MSB first. The target receives exactly that byte, and status bit2 reports the target's answer.
- R6: A data read while enable and master are 1 and transmit is 0 returns the last received byte and starts a new reception. In that reception, the master drives the ninth bit at the level of control bit4 (0 = ACK). With transmit set, the read returns the byte and starts nothing.
- R7: A control write that clears master while it was set produces a STOP: SDA rises while SCL is high. Complete then sets and both lines are released.
- R8: A control write with master and repeated start both 1, while master was already 1, produces a repeated START and sets complete. The following data write sends the address byte.
- R9: Complete reads 0 on the cycle after a byte or bus condition is started. Status bit1 is 1 during the ninth clock of a byte.
- R10: Inside a byte, successive SCL rises are CLK_HZ/SCL_HZ clock cycles apart, and SDA changes only while SCL is low.
- R11: Direct-control bit0 sets SDA and bit1 sets SCL (1 = release). These bits act on the pins only while enable is 0. Direct-status (offset 0x9) returns the SDA line level in bit0 and the SCL line level in bit1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | AW | Register offset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, valid while reg_rd is high |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A behavioural target on the bench acknowledges one address and answers reads with a known byte sequence. Outgoing bytes are chosen to separate the cases: all zeros, all ones, alternating nibbles, a byte with only its end bits set, and a byte the target refuses. Together these show that bit order and the sampled acknowledge are each right on their own. A wrong address is tried, and so are a repeated START that turns a write into a read and a two-byte read ending in NACK. Comparing the acknowledge levels the target logs against the NACK bit shows the level is applied per byte. Direct line control is tried with the engine disabled and then enabled, to show that it is gated.

// File: rtl/i2c_rc_pkg.sv
package i2c_rc_pkg;

    localparam int unsigned OFS_CAP   = 'h2;
    localparam int unsigned OFS_CTRL  = 'h4;
    localparam int unsigned OFS_DCTL  = 'h5;
    localparam int unsigned OFS_STAT  = 'h8;
    localparam int unsigned OFS_DSTAT = 'h9;
    localparam int unsigned OFS_DATA  = 'hC;

    localparam logic [7:0] CAP_VALUE = 8'h02;

    typedef enum logic [2:0] {OP_START, OP_RSTART, OP_STOP, OP_TX, OP_RX} op_e;
    typedef enum logic [1:0] {ST_IDLE, ST_COND, ST_BITS} st_e;

    // {scl, sda} for each half-bit slot of a bus condition
    function automatic logic [1:0] cond_lines(op_e op, logic [2:0] half);
        logic [1:0] v;
        case (op)
            OP_START:  v = (half == 3'd0) ? 2'b11 : (half == 3'd1) ? 2'b10 : 2'b00;
            OP_RSTART: v = (half == 3'd0) ? 2'b01 : (half == 3'd1) ? 2'b11 :
                           (half == 3'd2) ? 2'b10 : 2'b00;
            default:   v = (half == 3'd0) ? 2'b00 : (half == 3'd1) ? 2'b10 : 2'b11;
        endcase
        return v;
    endfunction

    // number of quarter-bit ticks a bus condition lasts
    function automatic logic [3:0] cond_len(op_e op);
        return (op == OP_RSTART) ? 4'd8 : 4'd6;
    endfunction

endpackage

// File: rtl/i2c_rc_tick.sv
module i2c_rc_tick #(
    parameter int unsigned QDIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          tick_d, tick_q;

    always_comb begin
        tick_d = run && (cnt_q == LAST);
        if (!run || cnt_q == LAST) cnt_d = '0;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q;

    generate
        if (QDIV > 1) begin : g_gap
            p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
                tick_q |=> !tick_q);
        end
    endgenerate

endmodule

// File: rtl/i2c_rc_engine.sv
module i2c_rc_engine
    import i2c_rc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       tick,
    input  logic       cmd_valid,
    input  op_e        cmd_op,
    input  logic [7:0] cmd_byte,
    input  logic       ack_lvl,
    input  logic       sda_in,
    output logic       busy,
    output logic       done,
    output logic       scl_o,
    output logic       sda_o,
    output logic [7:0] rx_byte,
    output logic       ack_in,
    output logic       ack_cyc
);
    typedef struct packed {
        st_e        st;
        op_e        op;
        logic [3:0] step;
        logic [3:0] bitn;
        logic [1:0] ph;
        logic [7:0] sh;
        logic       rx;
        logic       alvl;
        logic       scl;
        logic       sda;
        logic       ack;
        logic       done;
        logic       acyc;
    } eng_t;

    localparam eng_t ENG_RST = '{st: ST_IDLE, op: OP_STOP, step: '0, bitn: '0, ph: '0,
                                 sh: '0, rx: 1'b0, alvl: 1'b0, scl: 1'b1, sda: 1'b1,
                                 ack: 1'b0, done: 1'b0, acyc: 1'b0};

    eng_t q, n;
    logic [3:0] nstep;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        nstep  = q.step + 4'd1;
        if (abort) begin
            n = ENG_RST;
        end else begin
            case (q.st)
                ST_IDLE: if (cmd_valid) begin
                    n.op   = cmd_op;
                    n.alvl = ack_lvl;
                    n.step = '0;
                    n.bitn = '0;
                    n.ph   = '0;
                    n.rx   = (cmd_op == OP_RX);
                    if (cmd_op == OP_TX || cmd_op == OP_RX) begin
                        n.st  = ST_BITS;
                        n.sh  = cmd_byte;
                        n.scl = 1'b0;
                    end else begin
                        n.st = ST_COND;
                        if (cmd_op == OP_START) n.sh = cmd_byte;
                        {n.scl, n.sda} = cond_lines(cmd_op, 3'd0);
                    end
                end
                ST_COND: if (tick) begin
                    n.step = nstep;
                    if (nstep == cond_len(q.op)) begin
                        if (q.op == OP_START) begin
                            n.st   = ST_BITS;
                            n.bitn = '0;
                            n.ph   = '0;
                        end else begin
                            n.st   = ST_IDLE;
                            n.done = 1'b1;
                        end
                    end else begin
                        {n.scl, n.sda} = cond_lines(q.op, nstep[3:1]);
                    end
                end
                ST_BITS: if (tick) begin
                    n.ph = q.ph + 2'd1;
                    case (q.ph)
                        2'd0: begin
                            if (q.bitn == 4'd8) n.sda = q.rx ? q.alvl : 1'b1;
                            else                n.sda = q.rx ? 1'b1 : q.sh[7];
                        end
                        2'd1: begin
                            n.scl = 1'b1;
                            if (q.bitn == 4'd8) begin
                                if (!q.rx) n.ack = sda_in;
                            end else if (q.rx) begin
                                n.sh = {q.sh[6:0], sda_in};
                            end
                        end
                        2'd2: ;
                        default: begin
                            n.scl = 1'b0;
                            if (q.bitn == 4'd8) begin
                                n.st   = ST_IDLE;
                                n.done = 1'b1;
                                n.acyc = 1'b0;
                                n.sda  = 1'b1;
                            end else begin
                                n.bitn = q.bitn + 4'd1;
                                if (!q.rx) n.sh = {q.sh[6:0], 1'b0};
                                if (q.bitn == 4'd7) n.acyc = 1'b1;
                            end
                        end
                    endcase
                end
                default: n = ENG_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENG_RST;
        else        q <= n;
    end

    assign busy    = (q.st != ST_IDLE);
    assign done    = q.done;
    assign scl_o   = q.scl;
    assign sda_o   = q.sda;
    assign rx_byte = q.sh;
    assign ack_in  = q.ack;
    assign ack_cyc = q.acyc;

    p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BITS && q.scl && $past(q.scl) && $past(q.st == ST_BITS)) |-> $stable(q.sda));
    p_scl_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !abort) |=> $stable(q.scl));
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.st == ST_IDLE));

endmodule

// File: rtl/i2c_regctl_master.sv
module i2c_regctl_master
    import i2c_rc_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned SCL_HZ = 100_000,
    parameter int unsigned AW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_drive_low,
    output logic          sda_drive_low
);
    localparam int unsigned QDIV = CLK_HZ / (4 * SCL_HZ);

    typedef struct packed {
        logic       men;
        logic       msta;
        logic       mtx;
        logic       txak;
        logic [1:0] dctl;
        logic [7:0] txd;
        logic       lock;
        logic       mcf;
        logic       rxak;
    } regs_t;

    localparam regs_t REGS_RST = '{men: 1'b0, msta: 1'b0, mtx: 1'b0, txak: 1'b0,
                                   dctl: 2'b11, txd: '0, lock: 1'b0, mcf: 1'b0, rxak: 1'b0};

    regs_t q, n;

    logic       wr_ctrl, wr_dctl, wr_stat, wr_data, rd_stat, rd_data;
    logic       cmd_valid;
    op_e        cmd_op;
    logic [7:0] cmd_byte;
    logic       tick, eng_busy, eng_done, eng_scl, eng_sda, eng_ack, eng_acyc;
    logic [7:0] eng_rx;

    assign wr_ctrl = reg_wr && (reg_addr == AW'(OFS_CTRL));
    assign wr_dctl = reg_wr && (reg_addr == AW'(OFS_DCTL));
    assign wr_stat = reg_wr && (reg_addr == AW'(OFS_STAT));
    assign wr_data = reg_wr && (reg_addr == AW'(OFS_DATA));
    assign rd_stat = reg_rd && (reg_addr == AW'(OFS_STAT));
    assign rd_data = reg_rd && (reg_addr == AW'(OFS_DATA));

    always_comb begin
        n         = q;
        cmd_valid = 1'b0;
        cmd_op    = OP_TX;
        cmd_byte  = q.txd;
        if (wr_ctrl) begin
            n.men  = reg_wdata[0];
            n.msta = reg_wdata[1];
            n.mtx  = reg_wdata[3];
            n.txak = reg_wdata[4];
            if (reg_wdata[0] && q.men && !eng_busy) begin
                if (reg_wdata[1] && reg_wdata[2] && q.msta) begin
                    cmd_valid = 1'b1;
                    cmd_op    = OP_RSTART;
                end else if (reg_wdata[1] && !q.msta && reg_wdata[3]) begin
                    cmd_valid = 1'b1;
                    cmd_op    = OP_START;
                end else if (!reg_wdata[1] && q.msta) begin
                    cmd_valid = 1'b1;
                    cmd_op    = OP_STOP;
                end
            end
        end
        if (wr_dctl) n.dctl = reg_wdata[1:0];
        if (wr_data) begin
            n.txd = reg_wdata;
            if (q.men && q.msta && !eng_busy) begin
                cmd_valid = 1'b1;
                cmd_op    = OP_TX;
                cmd_byte  = reg_wdata;
            end
        end
        if (rd_data && q.men && q.msta && !q.mtx && !eng_busy) begin
            cmd_valid = 1'b1;
            cmd_op    = OP_RX;
        end
        if (rd_stat && !q.lock)         n.lock = 1'b1;
        if (wr_stat && reg_wdata[0])    n.lock = 1'b0;
        if (eng_done) begin
            n.mcf  = 1'b1;
            n.rxak = eng_ack;
        end
        if (cmd_valid) n.mcf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= n;
    end

    always_comb begin
        reg_rdata = 8'h00;
        if      (reg_addr == AW'(OFS_CAP))   reg_rdata = CAP_VALUE;
        else if (reg_addr == AW'(OFS_CTRL))  reg_rdata = {3'b000, q.txak, q.mtx, 1'b0, q.msta, q.men};
        else if (reg_addr == AW'(OFS_DCTL))  reg_rdata = {6'b0, q.dctl};
        else if (reg_addr == AW'(OFS_STAT))  reg_rdata = {4'b0, q.mcf, q.rxak, eng_acyc, q.lock};
        else if (reg_addr == AW'(OFS_DSTAT)) reg_rdata = {6'b0, scl_in, sda_in};
        else if (reg_addr == AW'(OFS_DATA))  reg_rdata = eng_rx;
    end

    assign scl_drive_low = q.men ? !eng_scl : !q.dctl[1];
    assign sda_drive_low = q.men ? !eng_sda : !q.dctl[0];

    i2c_rc_tick #(.QDIV(QDIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_busy),
        .tick  (tick)
    );

    i2c_rc_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (!q.men),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_byte  (cmd_byte),
        .ack_lvl   (q.txak),
        .sda_in    (sda_in),
        .busy      (eng_busy),
        .done      (eng_done),
        .scl_o     (eng_scl),
        .sda_o     (eng_sda),
        .rx_byte   (eng_rx),
        .ack_in    (eng_ack),
        .ack_cyc   (eng_acyc)
    );

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lock && !(wr_stat && reg_wdata[0])) |=> q.lock);
    p_mcf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !eng_done) |=> !q.mcf);
    p_done_sets_mcf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !cmd_valid) |=> q.mcf);

endmodule

// File: tb/i2c_regctl_master_tb.sv
module i2c_regctl_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 4_000_000;
    localparam int SCL_HZ     = 100_000;
    localparam int BIT_CYC    = CLK_HZ / SCL_HZ;
    localparam logic [6:0] TADDR = 7'h50;
    localparam logic [3:0] A_CAP = 4'h2, A_CTRL = 4'h4, A_DCTL = 4'h5,
                           A_STAT = 4'h8, A_DSTAT = 4'h9, A_DATA = 4'hC;
    // {byte sent, expected received-ack bit}
    localparam logic [8:0] WVEC [5] = '{ {8'h3C, 1'b0}, {8'h00, 1'b0}, {8'hFF, 1'b0},
                                         {8'hEE, 1'b1}, {8'h81, 1'b0} };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       scl_drive_low, sda_drive_low;
    logic       tgt_low = 1'b0;
    logic       scl_line, sda_line;

    int n_tests = 0;
    int n_fail  = 0;
    bit saw_acyc;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign scl_line = ~scl_drive_low;
    assign sda_line = ~(sda_drive_low | tgt_low);

    i2c_regctl_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .AW(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_line), .sda_in(sda_line),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
    );

    // behavioural target
    logic       ps = 1'b1, pd = 1'b1, active = 1'b0, first = 1'b0, addressed = 1'b0;
    logic       isrd = 1'b0, rdp = 1'b0, mack = 1'b0;
    logic [3:0] cnt = '0;
    logic [7:0] sh = '0, last_byte = '0, rdval = 8'hA5;
    logic [1:0] mack_log = '0;

    always @(posedge clk) begin
        ps <= scl_line;
        pd <= sda_line;
        if (scl_line && ps && pd && !sda_line) begin
            active <= 1'b1; cnt <= '0; first <= 1'b1; rdp <= 1'b0; tgt_low <= 1'b0; rdval <= 8'hA5;
        end else if (scl_line && ps && !pd && sda_line) begin
            active <= 1'b0; rdp <= 1'b0; tgt_low <= 1'b0;
        end else if (active && scl_line && !ps) begin
            cnt <= cnt + 4'd1;
            if (cnt < 4'd8 && !rdp) sh <= {sh[6:0], sda_line};
            if (cnt == 4'd8 && rdp) begin
                mack <= sda_line;
                mack_log <= {mack_log[0], sda_line};
            end
        end else if (active && !scl_line && ps) begin
            if (!rdp && cnt == 4'd8) begin
                if (first) begin
                    addressed <= (sh[7:1] == TADDR);
                    isrd      <= sh[0];
                    tgt_low   <= (sh[7:1] == TADDR);
                end else begin
                    tgt_low <= addressed && (sh != 8'hEE);
                    if (addressed) last_byte <= sh;
                end
            end else if (cnt == 4'd9) begin
                cnt   <= '0;
                first <= 1'b0;
                if (addressed && isrd && !(rdp && mack)) begin
                    logic [7:0] nv;
                    nv = rdp ? rdval + 8'h11 : rdval;
                    rdval   <= nv;
                    rdp     <= 1'b1;
                    tgt_low <= ~nv[7];
                end else begin
                    rdp     <= 1'b0;
                    tgt_low <= 1'b0;
                end
            end else if (rdp && cnt >= 4'd1 && cnt <= 4'd7) begin
                tgt_low <= ~rdval[7 - int'(cnt)];
            end else if (rdp && cnt == 4'd8) begin
                tgt_low <= 1'b0;
            end
        end
    end

    // SCL rise monitor
    int cyc = 0, last_rise = 0, last_iv = 0, rises = 0;
    logic pm = 1'b1;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        pm  <= scl_line;
        if (scl_line && !pm) begin
            last_iv   <= cyc - last_rise;
            last_rise <= cyc;
            rises     <= rises + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_mcf(input string tag);
        logic [7:0] v;
        saw_acyc = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            rd(A_STAT, v);
            if (v[1]) saw_acyc = 1'b1;
            if (v[3]) return;
        end
        chk(1'b0, {tag, " complete never set"}, 0, 1);
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        report();
    end

    initial begin
        logic [7:0] v;
        int r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(!scl_drive_low && !sda_drive_low, "R1 lines released", {scl_drive_low, sda_drive_low}, 0);
        rd(A_CTRL, v);  chk(v == 8'h00, "R1 control", v, 8'h00);
        rd(A_DCTL, v);  chk(v == 8'h03, "R1 direct-control", v, 8'h03);
        // R1 / R3 status and lock
        rd(A_STAT, v);  chk(v == 8'h00, "R1 R3 first status read", v, 8'h00);
        rd(A_STAT, v);  chk(v[0] == 1'b1, "R3 lock held", v[0], 1);
        wr(A_STAT, 8'h08);
        rd(A_STAT, v);  chk(v[0] == 1'b1, "R3 write bit0=0 ignored", v[0], 1);
        wr(A_STAT, 8'h01);
        rd(A_STAT, v);  chk(v[0] == 1'b0, "R3 released", v[0], 0);
        // R2 capability and unmapped
        rd(A_CAP, v);   chk(v == 8'h02, "R2 capability", v, 8'h02);
        rd(4'h0, v);    chk(v == 8'h00, "R2 unmapped", v, 8'h00);

        // R4 START + address write
        wr(A_DATA, {TADDR, 1'b0});
        wr(A_CTRL, 8'h09);
        wr(A_CTRL, 8'h0B);
        wait_mcf("R4");
        rd(A_STAT, v);  chk(v[2] == 1'b0, "R4 address acked", v[2], 0);
        chk(saw_acyc, "R9 ack-cycle bit seen", saw_acyc, 1);

        // R5 table of data bytes
        for (int i = 0; i < 5; i++) begin
            wr(A_DATA, WVEC[i][8:1]);
            if (i == 0) begin
                rd(A_STAT, v); chk(v[3] == 1'b0, "R9 complete cleared on start", v[3], 0);
            end
            wait_mcf("R5");
            rd(A_STAT, v);
            chk(v[2] == WVEC[i][0], "R5 received ack", v[2], WVEC[i][0]);
            chk(last_byte == WVEC[i][8:1], "R5 target byte", last_byte, WVEC[i][8:1]);
            chk(last_iv == BIT_CYC, "R10 SCL period", last_iv, BIT_CYC);
        end

        // R8 repeated START into read
        wr(A_CTRL, 8'h07);
        wait_mcf("R8");
        chk(active && first, "R8 target saw repeated start", {active, first}, 3);
        wr(A_DATA, {TADDR, 1'b1});
        wait_mcf("R8");
        rd(A_STAT, v);  chk(v[2] == 1'b0, "R8 read address acked", v[2], 0);

        // R6 two-byte read
        wr(A_CTRL, 8'h03);
        rd(A_DATA, v);
        wait_mcf("R6");
        wr(A_CTRL, 8'h13);
        rd(A_DATA, v);  chk(v == 8'hA5, "R6 first byte", v, 8'hA5);
        wait_mcf("R6");
        wr(A_CTRL, 8'h0B);
        rd(A_DATA, v);  chk(v == 8'hB6, "R6 second byte", v, 8'hB6);
        chk(mack_log == 2'b01, "R6 master ack levels", mack_log, 2'b01);
        r0 = rises;
        repeat (200) @(negedge clk);
        rd(A_STAT, v);
        chk(v[3] == 1'b1 && rises == r0, "R6 no reception with transmit set", rises - r0, 0);

        // R7 STOP
        wr(A_CTRL, 8'h09);
        wait_mcf("R7");
        #1;
        chk(!scl_drive_low && !sda_drive_low, "R7 lines released", {scl_drive_low, sda_drive_low}, 0);
        chk(!active, "R7 target saw stop", active, 0);

        // R4 wrong address refused
        wr(A_DATA, 8'h88);
        wr(A_CTRL, 8'h0B);
        wait_mcf("R4");
        rd(A_STAT, v);  chk(v[2] == 1'b1, "R4 wrong address nack", v[2], 1);
        wr(A_CTRL, 8'h09);
        wait_mcf("R7");

        // R11 direct control
        wr(A_CTRL, 8'h00);
        wr(A_DCTL, 8'h01);
        #1;
        chk(scl_drive_low && !sda_drive_low, "R11 SCL driven low", {scl_drive_low, sda_drive_low}, 2);
        rd(A_DSTAT, v); chk(v == 8'h01, "R11 direct status", v, 8'h01);
        wr(A_DCTL, 8'h02);
        rd(A_DSTAT, v); chk(v == 8'h02, "R11 SDA driven low", v, 8'h02);
        wr(A_DCTL, 8'h03);
        wr(A_DCTL, 8'h00);
        wr(A_CTRL, 8'h01);
        #1;
        chk(!scl_drive_low && !sda_drive_low, "R11 ignored while enabled", {scl_drive_low, sda_drive_low}, 0);
        rd(A_DSTAT, v); chk(v == 8'h03, "R11 lines high", v, 8'h03);

        report();
    end

endmodule